// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block owns a small group of pins that do double duty on a clock generator. Right after reset the pins are inputs: their drivers are switched off and the board's pull resistors set a level on each one. A power-on timer counts reference-clock cycles. When it expires, the block captures the pin levels once. One clock later it turns the pins into outputs. Each output carries its clock only when its own enable is set, and is held low otherwise.

Four of the captured levels form the frequency select code. The fifth chooses whether the peripheral clock pin runs at 24 MHz or at 48 MHz. A control-register override can replace the strapped code with a 5-bit code. In that code the top bit also switches spread-spectrum modulation. The block reports the code that takes effect and flags the reserved pattern. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `strap_seq_top`

## Requirements
- R1: While reset is held and until the straps are captured, every pin output enable is 0, every pin data output is 0 and `straps_valid_o` is 0.
- R2: The straps are captured, and `straps_valid_o` rises, at the (POR_CYCLES+2)-th rising clock edge after `rst_n_i` goes high: two edges of reset synchronization, then POR_CYCLES timer cycles.
- R3: The pin output enables rise together exactly one clock edge after `straps_valid_o` rises, so no pin drives in the cycle its level is captured.
- R4: Once captured, the strap values and everything derived from them stay unchanged whatever the pins do, until the next reset.
- R5: While the output enables are 0, `pin_do_o` is 0. Once they are 1, `pin_do_o[i]` equals `clk_src_i[i] & pin_en_i[i]`.
- R6: Pin bit 4 is the 24/48 strap: a captured 1 sets `clk24_sel_o` to 1 (24 MHz), a captured 0 sets it to 0 (48 MHz).
- R7: With `override_i` at 0, `freq_sel_o` is {1, FS3, FS2, FS1, FS0}, where pin bit i holds FSi, and `spread_en_o` is 1.
- R8: With `override_i` at 1, `freq_sel_o` equals `sel_reg_i` and `spread_en_o` equals `sel_reg_i[4]`.
- R9: `sel_reserved_o` is 1 exactly when `freq_sel_o[3:0]` is 4'b1110.
- R10: Each new reset discards the previous capture and captures the levels present at the next timer expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pin_di_i | input | 5 | Pin input levels; bits 3:0 are FS0..FS3, bit 4 is the 24/48 strap |
| clk_src_i | input | 5 | Internal clocks to be driven onto the pins |
| pin_en_i | input | 5 | Per-pin output enable from configuration |
| override_i | input | 1 | 1 selects the register code instead of the straps |
| sel_reg_i | input | 5 | Register-supplied frequency select code |
| pin_oe_o | output | 5 | Pin driver enables |
| pin_do_o | output | 5 | Pin driver data |
| straps_valid_o | output | 1 | Straps have been captured |
| fs_strap_o | output | 4 | Captured FS3..FS0 |
| clk24_sel_o | output | 1 | 1 = 24 MHz, 0 = 48 MHz on the peripheral clock pin |
| freq_sel_o | output | 5 | Effective frequency select code |
| spread_en_o | output | 1 | Spread-spectrum modulation enable |
| sel_reserved_o | output | 1 | Effective code is the reserved pattern |

## Verification
The bench sets POR_CYCLES to 8 instead of the default, which spans about two milliseconds of reference clock. With the short value it can reset the block once per table vector. Each reset lets it check the capture edge, the one-edge gap before the drivers turn on and the re-capture of new pin levels. It also covers both select sources, the reserved code in each mode and pin changes made after capture.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_WAIT  = 2'd0,
    SEQ_HELD  = 2'd1,
    SEQ_DRIVE = 2'd2
  } seq_state_e;

  localparam logic [3:0] RESERVED_CODE = 4'b1110;

  function automatic logic code_is_reserved(input logic [3:0] low_bits);
    return low_bits == RESERVED_CODE;
  endfunction

endpackage

// File: rtl/por_timer.sv
module por_timer #(
  parameter int POR_CYCLES = 28636
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en   = run_i;
  assign expire_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: the count never passes the terminal value
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LAST);

endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NFS = 4
) (
  input  logic           clk_i,
  input  logic           rst_n_i,
  input  logic           capture_i,
  input  logic [NFS:0]   pin_di_i,
  output logic [NFS-1:0] fs_o,
  output logic           clk24_o,
  output logic           valid_o
);
  logic [NFS-1:0] fs_q, fs_d;
  logic           c24_q, c24_d;
  logic           valid_q, valid_d;
  logic           load_en;

  assign load_en = capture_i && !valid_q;

  always_comb begin
    fs_d    = fs_q;
    c24_d   = c24_q;
    valid_d = valid_q;
    if (load_en) begin
      fs_d    = pin_di_i[NFS-1:0];
      c24_d   = pin_di_i[NFS];
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fs_q    <= '0;
      c24_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (load_en) begin
      fs_q    <= fs_d;
      c24_q   <= c24_d;
      valid_q <= valid_d;
    end
  end

  assign fs_o    = fs_q;
  assign clk24_o = c24_q;
  assign valid_o = valid_q;

  // R4: captured values hold once valid
  a_r4_straps_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_q |=> ($stable(fs_q) && $stable(c24_q) && valid_q));

endmodule

// File: rtl/sel_mux.sv
module sel_mux #(
  parameter int NFS = 4
) (
  input  logic           override_i,
  input  logic [NFS:0]   sel_reg_i,
  input  logic [NFS-1:0] fs_i,
  output logic [NFS:0]   freq_sel_o,
  output logic           spread_en_o,
  output logic           reserved_o
);
  import strap_seq_pkg::*;

  always_comb begin
    if (override_i) freq_sel_o = sel_reg_i;
    else            freq_sel_o = {1'b1, fs_i};
    spread_en_o = freq_sel_o[NFS];
    reserved_o  = code_is_reserved(freq_sel_o[3:0]);
  end

endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
  parameter int NPIN = 5
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            drive_req_i,
  input  logic [NPIN-1:0] clk_src_i,
  input  logic [NPIN-1:0] pin_en_i,
  output logic [NPIN-1:0] oe_o,
  output logic [NPIN-1:0] do_o
);
  logic [NPIN-1:0] oe_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic oe_d;
    assign oe_d = drive_req_i;
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) oe_q[i] <= 1'b0;
      else          oe_q[i] <= oe_d;
    end
    assign do_o[i] = oe_q[i] & pin_en_i[i] & clk_src_i[i];
  end

  assign oe_o = oe_q;

  // R5: undriven pins carry low data
  a_r5_low_when_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (oe_q == '0) |-> (do_o == '0));

endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top #(
  parameter int POR_CYCLES = 28636,
  parameter int NFS        = 4
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [4:0]   pin_di_i,
  input  logic [4:0]   clk_src_i,
  input  logic [4:0]   pin_en_i,
  input  logic         override_i,
  input  logic [4:0]   sel_reg_i,
  output logic [4:0]   pin_oe_o,
  output logic [4:0]   pin_do_o,
  output logic         straps_valid_o,
  output logic [3:0]   fs_strap_o,
  output logic         clk24_sel_o,
  output logic [4:0]   freq_sel_o,
  output logic         spread_en_o,
  output logic         sel_reserved_o
);
  import strap_seq_pkg::*;
  localparam int NPIN = NFS + 1;

  // reset synchronizer: asserted at once, released after two edges
  logic [1:0] rsync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rsync_q <= 2'b00;
    else          rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  seq_state_e state_q, state_d;
  logic       expire;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_WAIT:  if (expire) state_d = SEQ_HELD;
      SEQ_HELD:  state_d = SEQ_DRIVE;
      SEQ_DRIVE: state_d = SEQ_DRIVE;
      default:   state_d = SEQ_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_WAIT;
    else        state_q <= state_d;
  end

  por_timer #(.POR_CYCLES(POR_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n),
    .run_i    (state_q == SEQ_WAIT),
    .expire_o (expire)
  );

  logic [NFS-1:0] fs_cap;
  logic           c24_cap;
  logic           valid;

  strap_capture #(.NFS(NFS)) u_cap (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .capture_i (expire),
    .pin_di_i  (pin_di_i),
    .fs_o      (fs_cap),
    .clk24_o   (c24_cap),
    .valid_o   (valid)
  );

  sel_mux #(.NFS(NFS)) u_mux (
    .override_i  (override_i),
    .sel_reg_i   (sel_reg_i),
    .fs_i        (fs_cap),
    .freq_sel_o  (freq_sel_o),
    .spread_en_o (spread_en_o),
    .reserved_o  (sel_reserved_o)
  );

  pin_drive #(.NPIN(NPIN)) u_drv (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .drive_req_i (state_q != SEQ_WAIT),
    .clk_src_i   (clk_src_i),
    .pin_en_i    (pin_en_i),
    .oe_o        (pin_oe_o),
    .do_o        (pin_do_o)
  );

  assign straps_valid_o = valid;
  assign fs_strap_o     = fs_cap;
  assign clk24_sel_o    = c24_cap;

  // R1: no driver enabled before capture
  a_r1_quiet_before_capture: assert property (@(posedge clk_i) disable iff (!rst_n)
    !valid |-> (pin_oe_o == '0));
  // R3: drivers turn on one edge after capture
  a_r3_drive_after_capture: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(valid) |=> (pin_oe_o == '1));
  a_r3_no_drive_at_capture: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(valid) |-> (pin_oe_o == '0));
  // R7: strap mode always modulates
  a_r7_strap_spread: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid && !override_i) |-> (spread_en_o && freq_sel_o[3:0] == fs_strap_o));

endmodule

// File: tb/sim_strap_seq_top.sv
module sim_strap_seq_top;
  localparam int N = 8;

  logic       clk_i = 1'b0;
  logic       rst_n_i;
  logic [4:0] pin_di_i, clk_src_i, pin_en_i, sel_reg_i;
  logic       override_i;
  logic [4:0] pin_oe_o, pin_do_o, freq_sel_o;
  logic       straps_valid_o, clk24_sel_o, spread_en_o, sel_reserved_o;
  logic [3:0] fs_strap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  strap_seq_top #(.POR_CYCLES(N)) u0 (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .pin_di_i(pin_di_i), .clk_src_i(clk_src_i),
    .pin_en_i(pin_en_i), .override_i(override_i), .sel_reg_i(sel_reg_i),
    .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .straps_valid_o(straps_valid_o),
    .fs_strap_o(fs_strap_o), .clk24_sel_o(clk24_sel_o), .freq_sel_o(freq_sel_o),
    .spread_en_o(spread_en_o), .sel_reserved_o(sel_reserved_o)
  );

  // {strap[4:0], override, sel_reg[4:0], exp_freq[4:0], exp_spread, exp_rsv, exp_c24}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {5'b0_1101, 1'b0, 5'b00000, 5'b11101, 1'b1, 1'b0, 1'b0},
    {5'b1_1110, 1'b0, 5'b00000, 5'b11110, 1'b1, 1'b1, 1'b1},
    {5'b1_0000, 1'b1, 5'b01010, 5'b01010, 1'b0, 1'b0, 1'b1},
    {5'b0_0011, 1'b1, 5'b11110, 5'b11110, 1'b1, 1'b1, 1'b0},
    {5'b0_0110, 1'b1, 5'b01110, 5'b01110, 1'b0, 1'b1, 1'b0},
    {5'b1_0110, 1'b0, 5'b00000, 5'b10110, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n_i = 1'b0; pin_di_i = '0; clk_src_i = 5'h1F; pin_en_i = 5'h1F;
    override_i = 1'b0; sel_reg_i = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 oe in reset", 8'(pin_oe_o), 8'h00);
    check("R1 do in reset", 8'(pin_do_o), 8'h00);
    check("R1 valid in reset", 8'(straps_valid_o), 8'h0);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      rst_n_i = 1'b0;
      pin_di_i = e[18:14]; override_i = e[13]; sel_reg_i = e[12:8];
      clk_src_i = 5'h1F; pin_en_i = 5'h1F;
      repeat (2) @(negedge clk_i);
      rst_n_i = 1'b1;
      repeat (N + 1) @(negedge clk_i);
      // R2/R1: one edge before capture nothing is valid or driven
      check("R2 valid before capture", 8'(straps_valid_o), 8'h0);
      check("R1 do before capture", 8'(pin_do_o), 8'h00);
      @(negedge clk_i);
      check("R2 valid at capture", 8'(straps_valid_o), 8'h1);
      check("R3 oe at capture", 8'(pin_oe_o), 8'h00);
      // R10: each reset brings in the new pin levels
      check("R10 fs captured", 8'(fs_strap_o), 8'(e[17:14]));
      check("R6 24/48 select", 8'(clk24_sel_o), 8'(e[0]));
      check(e[13] ? "R8 freq code" : "R7 freq code", 8'(freq_sel_o), 8'(e[7:3]));
      check(e[13] ? "R8 spread" : "R7 spread", 8'(spread_en_o), 8'(e[2]));
      check("R9 reserved flag", 8'(sel_reserved_o), 8'(e[1]));
      @(negedge clk_i);
      check("R3 oe after capture", 8'(pin_oe_o), 8'h1F);
      check("R5 do enabled", 8'(pin_do_o), 8'h1F);
      // R4: pin changes after capture are ignored
      pin_di_i = ~e[18:14];
      repeat (3) @(negedge clk_i);
      check("R4 fs frozen", 8'(fs_strap_o), 8'(e[17:14]));
      check("R4 24/48 frozen", 8'(clk24_sel_o), 8'(e[0]));
      check("R4 code frozen", 8'(freq_sel_o), 8'(e[7:3]));
    end

    // R5: per-pin gating once driving
    pin_en_i = 5'b00101; clk_src_i = 5'h1F;
    #1 check("R5 pin enable gating", 8'(pin_do_o), 8'h05);
    clk_src_i = 5'b00100;
    #1 check("R5 clock source gating", 8'(pin_do_o), 8'h04);

    // R8/R9: override toggled live, reserved pattern in both modes
    override_i = 1'b1; sel_reg_i = 5'b11110;
    #1 check("R8 override live", 8'(freq_sel_o), 8'h1E);
    check("R9 reserved with override", 8'(sel_reserved_o), 8'h1);
    sel_reg_i = 5'b00001;
    #1 check("R8 spread off", 8'(spread_en_o), 8'h0);
    override_i = 1'b0;
    #1 check("R7 back to straps", 8'(freq_sel_o), 8'h16);

    // R1: reset asserted mid-run drops drivers at once
    @(negedge clk_i);
    rst_n_i = 1'b0;
    #1 check("R1 oe on reset", 8'(pin_oe_o), 8'h00);
    check("R1 valid on reset", 8'(straps_valid_o), 8'h0);

    finish_run();
  end
endmodule